// File: doc/BRIEF.md
# Fail-Safe Overtemperature Fan Override

This block watches the stream of temperature conversions from an internal (local) sensor and a remote diode sensor. On every conversion strobe it compares each reading with that sensor's active over-temperature limit. When a sensor stays hot long enough, the block forces the fan drive to full scale. It also pulls an active-low thermal alarm flag low and suppresses any request to switch the fan off. This gives a hardware safety net that works even when system software has failed.

Two sets of limits exist. Fixed defaults of 70 °C for the local sensor and 100 °C for the remote sensor apply out of reset. A pair of user limit registers can be written through a small register port. A write-once lock bit then makes the user limits active and freezes them until the next reset. Each sensor applies hysteresis and a run filter. The override starts after three consecutive readings above the limit. It ends after three consecutive readings at least 5 degrees under the limit.

Top module: `fan_override_guard`

## Requirements
- R1: After reset, force_full_o is 0, therm_no is 1, the lock reads 0, the user local limit reads 70 and the user remote limit reads 100.
- R2: While unlocked, the fixed limits (local 70, remote 100) decide the override. The user limit registers accept writes and read back the written value, but they are not used.
- R3: The control register at address 2 holds the lock in bit 0. Writing 1 sets it. Writing 0 leaves it unchanged, and only reset clears it.
- R4: While locked, the user limits (address 0 local, address 1 remote) are the active limits, and writes to addresses 0 and 1 are ignored.
- R5: A sensor enters override only after three consecutive conversions that read strictly greater than its active limit. A reading equal to the limit or lower restarts the run.
- R6: A sensor in override leaves it only after three consecutive conversions that read at or below its limit minus 5. Any warmer reading restarts the run and keeps the override.
- R7: Each sensor keeps its own state. force_full_o is high while either sensor is in override.
- R8: therm_no is the inverse of force_full_o. fan_off_o follows fan_off_req_i but is 0 whenever force_full_o is 1.
- R9: Readings count only in cycles with conv_valid_i high. Without the strobe, the override state does not change.
- R10: Readings and limits are 8-bit two's complement in whole degrees, and the comparisons are signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_valid_i | input | 1 | New conversion result strobe |
| temp_loc_i | input | 8 | Local sensor reading, signed degrees |
| temp_rem_i | input | 8 | Remote sensor reading, signed degrees |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address: 0 local limit, 1 remote limit, 2 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (address 3 reads 0) |
| fan_off_req_i | input | 1 | Fan-off request from normal control |
| fan_off_o | output | 1 | Fan-off request after override gating |
| force_full_o | output | 1 | Force fan drive to full scale |
| therm_no | output | 1 | Thermal alarm, active low |

## Verification
On every cycle, the assertions check the following:
- The lock never falls.
- Locked limits never change.
- A sensor's override state moves only on a strobe that carries a qualifying reading: above the limit to enter, cool enough to leave.
- The run counter stays within its range.

Only the bench scenarios can show the counting itself:
- That exactly the third consecutive reading flips the state, and that equal or in-band readings restart the run.
- Which limit set is active before and after locking, and that signed limits below zero work.
- That the two sensors combine independently.

// File: rtl/fog_pkg.sv
package fog_pkg;
  localparam int TEMP_W    = 8;
  localparam int NUM_SENSE = 2;
  localparam int SENSE_LOC = 0;
  localparam int SENSE_REM = 1;

  typedef logic signed [TEMP_W-1:0] temp_t;

  localparam logic [1:0] ADDR_LIM_LOC = 2'd0;
  localparam logic [1:0] ADDR_LIM_REM = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;
endpackage

// File: rtl/fog_limit_bank.sv
module fog_limit_bank
  import fog_pkg::*;
#(
  parameter int DEF_LOC     = 70,
  parameter int DEF_REM     = 100,
  parameter int USR_RST_LOC = 70,
  parameter int USR_RST_REM = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output temp_t       lim_loc_o,
  output temp_t       lim_rem_o
);
  localparam temp_t DEF_LOC_T = temp_t'(DEF_LOC);
  localparam temp_t DEF_REM_T = temp_t'(DEF_REM);
  localparam temp_t USR_LOC_T = temp_t'(USR_RST_LOC);
  localparam temp_t USR_REM_T = temp_t'(USR_RST_REM);

  temp_t usr_loc_q, usr_rem_q;
  logic  lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_loc_q <= USR_LOC_T;
      usr_rem_q <= USR_REM_T;
      lock_q    <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_LIM_LOC: if (!lock_q) usr_loc_q <= temp_t'(wdata_i);
        ADDR_LIM_REM: if (!lock_q) usr_rem_q <= temp_t'(wdata_i);
        ADDR_CTRL:    if (wdata_i[0]) lock_q <= 1'b1;  // set-only
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_LIM_LOC: rdata_o = usr_loc_q;
      ADDR_LIM_REM: rdata_o = usr_rem_q;
      ADDR_CTRL:    rdata_o = {7'd0, lock_q};
      default:      rdata_o = 8'd0;
    endcase
  end

  assign lim_loc_o = lock_q ? usr_loc_q : DEF_LOC_T;
  assign lim_rem_o = lock_q ? usr_rem_q : DEF_REM_T;

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_frozen_limits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(usr_loc_q) && $stable(usr_rem_q)));
endmodule

// File: rtl/fog_hyst_track.sv
module fog_hyst_track
  import fog_pkg::*;
#(
  parameter int RUN_LEN = 3,
  parameter int HYST    = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sample_i,
  input  temp_t temp_i,
  input  temp_t limit_i,
  output logic  hot_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
  localparam logic signed [TEMP_W:0] HYST_S = (TEMP_W+1)'(HYST);

  logic          hot_q;
  logic [CW-1:0] cnt_q;
  logic signed [TEMP_W:0] t_ext, l_ext;
  logic over, cool, step;

  assign t_ext = {temp_i[TEMP_W-1], temp_i};
  assign l_ext = {limit_i[TEMP_W-1], limit_i};
  assign over  = temp_i > limit_i;
  assign cool  = t_ext <= (l_ext - HYST_S);  // widened so limit-HYST cannot wrap
  assign step  = hot_q ? cool : over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
      cnt_q <= '0;
    end else if (sample_i) begin
      if (step) begin
        if (cnt_q == LAST) begin
          hot_q <= ~hot_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign hot_o = hot_q;

  assert_rise_needs_over_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hot_q) |-> $past(sample_i && over));

  assert_fall_needs_cool_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hot_q) |-> $past(sample_i && cool));

  assert_hold_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(hot_q));

  assert_run_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(RUN_LEN));
endmodule

// File: rtl/fan_override_guard.sv
module fan_override_guard
  import fog_pkg::*;
#(
  parameter int RUN_LEN     = 3,
  parameter int HYST        = 5,
  parameter int DEF_LOC     = 70,
  parameter int DEF_REM     = 100,
  parameter int USR_RST_LOC = 70,
  parameter int USR_RST_REM = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_valid_i,
  input  logic [7:0] temp_loc_i,
  input  logic [7:0] temp_rem_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       fan_off_req_i,
  output logic       fan_off_o,
  output logic       force_full_o,
  output logic       therm_no
);
  temp_t lim_loc, lim_rem;
  temp_t temps [NUM_SENSE];
  temp_t lims  [NUM_SENSE];
  logic [NUM_SENSE-1:0] hot;

  fog_limit_bank #(
    .DEF_LOC(DEF_LOC), .DEF_REM(DEF_REM),
    .USR_RST_LOC(USR_RST_LOC), .USR_RST_REM(USR_RST_REM)
  ) u_limits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .lim_loc_o(lim_loc),
    .lim_rem_o(lim_rem)
  );

  assign temps[SENSE_LOC] = temp_t'(temp_loc_i);
  assign temps[SENSE_REM] = temp_t'(temp_rem_i);
  assign lims[SENSE_LOC]  = lim_loc;
  assign lims[SENSE_REM]  = lim_rem;

  for (genvar s = 0; s < NUM_SENSE; s++) begin : g_sense
    fog_hyst_track #(.RUN_LEN(RUN_LEN), .HYST(HYST)) u_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(conv_valid_i),
      .temp_i  (temps[s]),
      .limit_i (lims[s]),
      .hot_o   (hot[s])
    );
  end

  assign force_full_o = |hot;
  assign therm_no     = ~force_full_o;
  assign fan_off_o    = fan_off_req_i & ~force_full_o;
endmodule

// File: tb/fan_override_guard_bench.sv
module fan_override_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_valid = 1'b0;
  logic [7:0] t_loc = 8'd0, t_rem = 8'd0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       fan_req = 1'b0;
  logic       fan_off, force_full, therm_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  fan_override_guard u_fan_override_guard (
    .clk_i(clk), .rst_ni(rst_n), .conv_valid_i(conv_valid),
    .temp_loc_i(t_loc), .temp_rem_i(t_rem),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fan_off_req_i(fan_req), .fan_off_o(fan_off),
    .force_full_o(force_full), .therm_no(therm_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // driver: one conversion, expected override pushed to the scoreboard
  task automatic conv(string tag, int loc, int rem, bit exp_force);
    @(negedge clk);
    conv_valid = 1'b1; t_loc = 8'(loc); t_rem = 8'(rem);
    exp_q.push_back(exp_force); tag_q.push_back(tag);
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  // monitor
  always begin
    @(posedge clk);
    if (conv_valid && rst_n) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard underflow actual=%0d expected=none", force_full);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({t, " force"}, {7'd0, force_full}, {7'd0, e});
        chk({t, " therm"}, {7'd0, therm_n}, {7'd0, ~e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 force reset", {7'd0, force_full}, 8'd0);
    chk("R1 therm reset", {7'd0, therm_n}, 8'd1);
    rst_n = 1'b1;
    rd_chk("R1 usr loc reset", 2'd0, 8'd70);
    rd_chk("R1 usr rem reset", 2'd1, 8'd100);
    rd_chk("R1 lock reset", 2'd2, 8'd0);

    // R2: unlocked, user regs writable but defaults active
    wr(2'd1, 8'd50);
    rd_chk("R2 usr rem readback", 2'd1, 8'd50);
    conv("R2", -128, 60, 0); conv("R2", 0, 60, 0); conv("R2", 0, 60, 0);

    // R5: equality does not count, broken run restarts
    conv("R5 eq", 70, 0, 0); conv("R5 eq", 70, 0, 0); conv("R5 eq", 70, 0, 0);
    conv("R5", 71, 0, 0); conv("R5", 71, 0, 0); conv("R5 break", 70, 0, 0);
    conv("R5", 71, 0, 0); conv("R5", 71, 0, 0); conv("R5 third", 71, 0, 1);

    // R6: release after three at or below 65
    conv("R6", 65, 0, 1); conv("R6", 65, 0, 1); conv("R6 break", 66, 0, 1);
    conv("R6", 65, 0, 1); conv("R6", 65, 0, 1); conv("R6 third", 65, 0, 0);

    // R9: hot readings without strobe do nothing
    @(negedge clk); t_loc = 8'd120; t_rem = 8'd120;
    repeat (5) @(negedge clk);
    #1;
    chk("R9 no strobe", {7'd0, force_full}, 8'd0);

    // R7: independent sensors, OR of states
    conv("R7", 0, 101, 0); conv("R7", 0, 101, 0); conv("R7 rem", 0, 101, 1);
    conv("R7", 71, 101, 1); conv("R7", 71, 101, 1); conv("R7 both", 71, 101, 1);
    conv("R7", 71, 95, 1); conv("R7", 71, 95, 1); conv("R7 loc only", 71, 95, 1);
    @(negedge clk); fan_req = 1'b1; #1;
    chk("R8 fan_off gated", {7'd0, fan_off}, 8'd0);
    conv("R7", 60, 0, 1); conv("R7", 60, 0, 1); conv("R7 none", 60, 0, 0);
    @(negedge clk); #1;
    chk("R8 fan_off passes", {7'd0, fan_off}, 8'd1);
    fan_req = 1'b0;

    // R3: lock is set-only
    wr(2'd2, 8'd0);
    rd_chk("R3 write 0", 2'd2, 8'd0);
    wr(2'd0, 8'hF6);  // -10
    wr(2'd2, 8'd1);
    rd_chk("R3 lock set", 2'd2, 8'd1);
    wr(2'd2, 8'd0);
    rd_chk("R3 lock sticky", 2'd2, 8'd1);

    // R4: locked limits frozen and active
    wr(2'd1, 8'd120);
    rd_chk("R4 rem frozen", 2'd1, 8'd50);
    wr(2'd0, 8'd0);
    rd_chk("R4 loc frozen", 2'd0, 8'hF6);
    conv("R4", -20, 60, 0); conv("R4", -20, 60, 0); conv("R4 user rem", -20, 60, 1);
    conv("R4", -20, 45, 1); conv("R4", -20, 45, 1); conv("R4 release", -20, 45, 0);

    // R10: signed limit -10
    conv("R10", -5, 0, 0); conv("R10", -5, 0, 0); conv("R10 neg hot", -5, 0, 1);
    conv("R10", -15, 0, 1); conv("R10", -15, 0, 1); conv("R10 neg cool", -15, 0, 0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule